// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one 8-bit output compare channel that sits beside a timer/counter. It holds the compare value. It compares that value against the counter value supplied by the counter logic on every timer tick. On a hit it raises a sticky match flag and moves an internal waveform bit. A 2-bit action field sets the move. When that field is non-zero, the waveform bit drives the pin in place of the normal port data.

In non-PWM operation, CPU writes land in the active compare value at once. In PWM operation they land in a holding register. The active value is refreshed from the holding register only on a tick at which the counter logic signals a turning point, top or bottom. This keeps every PWM period symmetric.

A CPU write to the counter makes the next timer tick unable to match, even if that tick arrives many cycles later. This lets software load the counter with the compare value without a false hit. In non-PWM operation a force strobe moves the waveform bit as a hit would. It does not touch the flag.

Top module: `ocmp_chan`

## Requirements
- R1: After reset the match flag, waveform bit, pin override and active compare value are all 0.
- R2: With `pwm_en` low, a `cmp_wr` cycle makes `cmp_active` equal `cmp_wdata` from the next cycle on.
- R3: With `pwm_en` high, `cmp_wr` only fills the holding register. `cmp_active` takes the holding value at the end of a cycle with both `tick` and `turn_pt` high, and at no other time while `pwm_en` is high.
- R4: A hit is a cycle with `tick` high, no block pending and `cnt_val` equal to `cmp_active`. A hit sets `match_flag` the next cycle. The flag stays set, and nothing happens on cycles without `tick`.
- R5: `flag_clr` clears `match_flag` the next cycle. A hit in the same cycle wins and leaves the flag set.
- R6: With `pwm_en` low, the action field `act_mode` on a hit does the following: 00 leaves the waveform bit, 01 toggles it, 10 clears it and 11 sets it.
- R7: With `pwm_en` high, a hit with `act_mode` 01 toggles the waveform bit. With 10 it clears the bit while `cnt_down` is 0 and sets it while `cnt_down` is 1. With 11 it does the reverse. With 00 it leaves the bit.
- R8: With `pwm_en` low and no hit, `force_stb` applies the R6 action to the waveform bit and leaves `match_flag` unchanged. With `pwm_en` high, `force_stb` has no effect.
- R9: A `cnt_wr` cycle blocks the first tick that comes after it. That tick has no effect on the flag or the waveform bit, however many tick-free cycles come between. The tick in the same cycle as the write is not blocked. A blocked tick uses up the block.
- R10: A change of `act_mode` applies from the very next hit or force. A change of `pwm_en` leaves the waveform bit as it was.
- R11: `pin_ovr` is 1 exactly while `act_mode` is non-zero, and `wave_out` follows the internal waveform bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer tick enable |
| cnt_val | input | 8 | Current counter value |
| cnt_down | input | 1 | Counter is counting down |
| turn_pt | input | 1 | Counter is at top or bottom (reload point) |
| cnt_wr | input | 1 | CPU write to the counter |
| pwm_en | input | 1 | PWM operation (double buffering on) |
| cmp_wr | input | 1 | CPU write to the compare value |
| cmp_wdata | input | 8 | Compare write data |
| act_mode | input | 2 | Action on hit or force |
| force_stb | input | 1 | Force strobe |
| flag_clr | input | 1 | Write-one-to-clear of the match flag |
| match_flag | output | 1 | Sticky match flag |
| wave_out | output | 1 | Waveform bit |
| pin_ovr | output | 1 | Waveform bit overrides the port data |
| cmp_active | output | 8 | Active compare value |

## Verification
A stuck or stale block bit shows as a missing or extra flag on a tick that matches. That is at most one tick after the counter write. A wrong holding or active value shows in `cmp_active` on the cycle after the reload tick. It also shows as a hit at the wrong count. A wrong waveform state is visible on `wave_out` in the cycle right after the offending hit or force. It stays visible until the next action. The reference model is compared on every clock, so each of these faults is caught within one cycle of reaching the ports.

// File: rtl/ocmp_chan.sv
module ocmp_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cnt_val,
  input  logic         cnt_down,
  input  logic         turn_pt,
  input  logic         cnt_wr,
  input  logic         pwm_en,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic [1:0]   act_mode,
  input  logic         force_stb,
  input  logic         flag_clr,
  output logic         match_flag,
  output logic         wave_out,
  output logic         pin_ovr,
  output logic [W-1:0] cmp_active
);

  logic [W-1:0] hold_q, act_q;
  logic         blk_q, wave_q, flag_q;
  logic         hit, frc, wave_nx;

  assign hit = tick && !blk_q && (cnt_val == act_q);
  assign frc = force_stb && !pwm_en && !hit;

  always_comb begin
    wave_nx = wave_q;
    if (hit) begin
      unique case (act_mode)
        2'b01: wave_nx = ~wave_q;
        2'b10: wave_nx = pwm_en ? cnt_down : 1'b0;
        2'b11: wave_nx = pwm_en ? ~cnt_down : 1'b1;
        default: wave_nx = wave_q;
      endcase
    end else if (frc) begin
      unique case (act_mode)
        2'b01: wave_nx = ~wave_q;
        2'b10: wave_nx = 1'b0;
        2'b11: wave_nx = 1'b1;
        default: wave_nx = wave_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      act_q  <= '0;
      blk_q  <= 1'b0;
      wave_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (cmp_wr) hold_q <= cmp_wdata;
      if (cmp_wr && !pwm_en) act_q <= cmp_wdata;
      else if (pwm_en && tick && turn_pt) act_q <= hold_q;
      blk_q  <= tick ? cnt_wr : (blk_q | cnt_wr);
      wave_q <= wave_nx;
      if (hit) flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  assign match_flag = flag_q;
  assign wave_out   = wave_q;
  assign pin_ovr    = |act_mode;
  assign cmp_active = act_q;

  // R4
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flag) |-> $past(tick));
  // R5
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !tick) |=> !match_flag);
  // R9
  blk_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && blk_q && !force_stb) |=> $stable(wave_out));
  // R9
  blk_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && blk_q && !match_flag && !flag_clr) |=> !match_flag);
  // R3
  pwm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && !(tick && turn_pt)) |=> $stable(cmp_active));
  // R8
  pwm_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && !tick) |=> $stable(wave_out));
  // R10
  wave_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !force_stb) |=> $stable(wave_out));

endmodule

// File: tb/ocmp_chan_test.sv
module ocmp_chan_test;
  logic clk = 0, rst_n = 0;
  logic tick = 0, cnt_down = 0, turn_pt = 0, cnt_wr = 0, pwm_en = 0;
  logic cmp_wr = 0, force_stb = 0, flag_clr = 0;
  logic [7:0] cnt_val = 0, cmp_wdata = 0;
  logic [1:0] act_mode = 0;
  logic match_flag, wave_out, pin_ovr;
  logic [7:0] cmp_active;

  int vecs = 0, errs = 0;
  string req = "R1";
  int m_act, m_hold, m_wave, m_flag, m_blk;

  ocmp_chan uut (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_hold = 0; m_wave = 0; m_flag = 0; m_blk = 0;
    end else begin
      bit h;
      int nw;
      h = tick && (m_blk == 0) && (int'(cnt_val) == m_act);
      nw = m_wave;
      if (h) begin
        if (act_mode == 1) nw = 1 - m_wave;
        else if (act_mode == 2) nw = pwm_en ? int'(cnt_down) : 0;
        else if (act_mode == 3) nw = pwm_en ? 1 - int'(cnt_down) : 1;
      end else if (force_stb && !pwm_en) begin
        if (act_mode == 1) nw = 1 - m_wave;
        else if (act_mode == 2) nw = 0;
        else if (act_mode == 3) nw = 1;
      end
      if (h) m_flag = 1; else if (flag_clr) m_flag = 0;
      if (cmp_wr && !pwm_en) m_act = cmp_wdata;
      else if (pwm_en && tick && turn_pt) m_act = m_hold;
      if (cmp_wr) m_hold = cmp_wdata;
      m_blk = tick ? int'(cnt_wr) : ((m_blk != 0 || cnt_wr) ? 1 : 0);
      m_wave = nw;
    end
  end

  task automatic chk(string what, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    chk("match_flag", match_flag, m_flag);
    chk("wave_out", wave_out, m_wave);
    chk("pin_ovr", pin_ovr, act_mode != 0);
    chk("cmp_active", cmp_active, m_act);
    tick = 0; cnt_wr = 0; cmp_wr = 0; force_stb = 0; flag_clr = 0; turn_pt = 0;
  endtask

  task automatic wr_cmp(int v);
    cmp_wr = 1; cmp_wdata = 8'(v); cyc();
  endtask

  task automatic tk(int c);
    tick = 1; cnt_val = 8'(c); cyc();
  endtask

  initial begin
    #3_000_000;
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    req = "R1"; cyc();
    chk("R1 flag at reset", match_flag, 0);
    chk("R1 active at reset", cmp_active, 0);
    rst_n = 1;
    req = "R2"; wr_cmp(8'h40);
    chk("R2 direct write", cmp_active, 8'h40);
    req = "R4"; tk(8'h3f); tk(8'h40);
    chk("R4 flag set", match_flag, 1);
    cnt_val = 8'h40; cyc(); cyc();
    chk("R4 no tick no change", match_flag, 1);
    req = "R5"; flag_clr = 1; cyc();
    chk("R5 cleared", match_flag, 0);
    flag_clr = 1; tk(8'h40);
    chk("R5 set wins", match_flag, 1);
    req = "R6";
    for (int m = 0; m < 4; m++) begin
      act_mode = 2'(m); tk(8'h40); tk(8'h40); tk(8'h41);
    end
    req = "R8"; act_mode = 2'b01; flag_clr = 1; cyc();
    force_stb = 1; cyc();
    chk("R8 force no flag", match_flag, 0);
    act_mode = 2'b10; force_stb = 1; cyc();
    act_mode = 2'b11; force_stb = 1; cyc();
    chk("R8 force set", wave_out, 1);
    req = "R9"; cnt_wr = 1; cyc(); repeat (5) cyc();
    act_mode = 2'b10; tk(8'h40);
    chk("R9 blocked flag", match_flag, 0);
    chk("R9 blocked wave", wave_out, 1);
    tk(8'h40);
    chk("R9 block consumed", wave_out, 0);
    cnt_wr = 1; tk(8'h40); tk(8'h40); tk(8'h40);
    req = "R3"; pwm_en = 1; wr_cmp(8'h80);
    chk("R3 held", cmp_active, 8'h40);
    tk(8'h10);
    chk("R3 no reload", cmp_active, 8'h40);
    turn_pt = 1; tk(8'hff);
    chk("R3 reload", cmp_active, 8'h80);
    req = "R8"; act_mode = 2'b01; force_stb = 1; cyc();
    req = "R7";
    for (int m = 0; m < 4; m++) begin
      act_mode = 2'(m);
      cnt_down = 0; tk(8'h80); cnt_down = 1; tk(8'h80);
    end
    req = "R10"; act_mode = 2'b11; cnt_down = 0; tk(8'h80);
    pwm_en = 0; cyc();
    chk("R10 wave kept", wave_out, 1);
    act_mode = 2'b10; force_stb = 1; cyc();
    chk("R10 immediate mode", wave_out, 0);
    req = "R11"; act_mode = 0; cyc(); act_mode = 2'b10; cyc();
    req = "R9";
    for (int i = 0; i < 3000; i++) begin
      tick = ($urandom % 3) != 0;
      cnt_val = 8'($urandom % 4 + 8'h7e);
      cnt_down = $urandom % 2;
      turn_pt = ($urandom % 4) == 0;
      cnt_wr = ($urandom % 5) == 0;
      if (($urandom % 50) == 0) pwm_en = ~pwm_en;
      cmp_wr = ($urandom % 8) == 0;
      cmp_wdata = 8'($urandom % 4 + 8'h7e);
      act_mode = 2'($urandom);
      force_stb = ($urandom % 6) == 0;
      flag_clr = ($urandom % 4) == 0;
      cyc();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule